// File: doc/BRIEF.md
# Masked interrupt level encoder

This block collects thirteen level-sensitive interrupt request lines, brings them into the local clock domain, and places each one at a fixed bit of a 16-bit pending word. A software-written enable mask gates that word. The surviving sources are reduced to one 4-bit interrupt level for a CPU. Each source has a fixed priority code, and the smallest code among the enabled, pending sources wins. The level output is the inverse of the winning code, so an idle block drives 0 and the most urgent source drives 15.

A small 16-bit register port sits beside the encoder. It holds the enable mask, a general-purpose output port that drives external pins, a fixed version word, and a power-off control. The power-off control is a two-state machine. In `PWR_RUN` it waits. A write to the power-off offset with bit 0 set moves it to `PWR_PULSE`, where `shutdown_o` is high. `PWR_PULSE` always returns to `PWR_RUN` on the next clock. A power-off write that arrives while the machine is in `PWR_PULSE` is absorbed. Requests are not edge-detected or latched: a source counts only while its line is high.

Top module: `masked_irq_level_enc`

## Requirements
- R1: After reset, `level_o`, `port_o`, `shutdown_o` and the enable mask are all 0, and `rvalid_o` is low.
- R2: Request line `req_i[k]` has priority code k. It sets pending bit 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15 for k = 0 through 12 respectively. Pending bits 1, 2 and 3 are never set.
- R3: A source takes part in selection only while its request is high and the mask bit at its pending position is 1. When its request drops, the source stops taking part; nothing is latched.
- R4: The smallest priority code among the taking-part sources is chosen, and `level_o` equals that code XOR 15. With no source taking part, `level_o` is 0.
- R5: A change on `req_i` reaches `level_o` on the third rising clock edge after the change: two synchronizer flops, then the output register.
- R6: The enable mask is read/write at byte offset 0x00. A mask write at one clock edge changes `level_o` at the following edge.
- R7: Offset 0x36 is a read/write output-port register whose value drives `port_o`.
- R8: A write to offset 0x30 with bit 0 = 1 makes `shutdown_o` high for exactly the one cycle after the write edge. A write with bit 0 = 0 gives no pulse. Reads of 0x30 return 0.
- R9: Offset 0x32 always reads 0x0010, and writes to it are ignored.
- R10: Reads of any other offset return 0, and writes to other offsets change neither the mask nor the output port.
- R11: A read (`cs_i`=1, `we_i`=0) yields `rvalid_o`=1 with its data on `rdata_o` one cycle later. Otherwise `rvalid_o` is 0 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 13 | Level interrupt requests; bit k has priority code k |
| cs_i | input | 1 | Register access select |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset in the 0x40-byte window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid one cycle after a read |
| rvalid_o | output | 1 | Read data valid |
| level_o | output | 4 | Inverted priority code of the winning source, 0 when idle |
| port_o | output | 16 | General-purpose output port |
| shutdown_o | output | 1 | One-cycle power-off request |

## Verification
The assertions assume three things about the register port: at most one access is made per cycle, `cs_i`, `we_i`, `addr_i` and `wdata_i` are stable around each rising edge, and every access is a full 16-bit word at a decoded offset. The request lines need not be synchronous. The stimulus changes every input only at the falling clock edge and presents each bus access for exactly one cycle. Random request and mask values are mixed with directed cases for the idle, most-urgent, least-urgent and masked-off sources.

// File: rtl/irl_pkg.sv
package irl_pkg;

    localparam int unsigned NUM_SRC    = 13;
    localparam int unsigned DATA_W     = 16;
    localparam int unsigned ADDR_W     = 6;
    localparam int unsigned LEVEL_W    = 4;
    localparam int unsigned SYNC_DEPTH = 2;

    localparam logic [LEVEL_W-1:0] IDLE_CODE = {LEVEL_W{1'b1}};

    localparam logic [ADDR_W-1:0] OFS_MASK = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_PWR  = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_VER  = 6'h32;
    localparam logic [ADDR_W-1:0] OFS_PORT = 6'h36;

    localparam logic [DATA_W-1:0] VERSION_WORD = 16'h0010;

    typedef enum logic {
        PWR_RUN   = 1'b0,
        PWR_PULSE = 1'b1
    } pwr_state_e;

    // Pending-word position of the source with priority code k.
    function automatic int unsigned src_bit(input int unsigned k);
        unique case (k)
            0:       return 11;
            1:       return 9;
            2:       return 8;
            3:       return 12;
            4:       return 10;
            5:       return 6;
            6:       return 5;
            7:       return 4;
            8:       return 7;
            9:       return 14;
            10:      return 13;
            11:      return 0;
            default: return 15;
        endcase
    endfunction

endpackage

// File: rtl/irl_sync.sv
module irl_sync #(
    parameter int unsigned WIDTH  = 13,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irl_prio_enc.sv
module irl_prio_enc
    import irl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl_i,
    input  logic [DATA_W-1:0]  mask_i,
    output logic [LEVEL_W-1:0] level_o
);

    logic [DATA_W-1:0]  pend_w;
    logic [DATA_W-1:0]  armed_w;
    logic [LEVEL_W-1:0] win_code;

    // Scatter synchronized sources onto their fixed pending positions.
    always_comb begin
        pend_w = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            pend_w[src_bit(k)] = src_lvl_i[k];
        end
    end

    assign armed_w = pend_w & mask_i;

    // Scan from the highest code down so that the lowest armed code remains.
    always_comb begin
        win_code = IDLE_CODE;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (armed_w[src_bit(k)]) begin
                win_code = LEVEL_W'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= '0;
        end else begin
            level_o <= win_code ^ IDLE_CODE;
        end
    end

    // R4: nothing armed gives an idle level on the next edge
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_w == '0) |=> (level_o == '0));

    // R4: the code-0 source, when armed, always drives the top level
    a_r4_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lvl_i[0] && mask_i[11]) |=> (level_o == IDLE_CODE));

    // R2: unused pending positions never contribute
    a_r2_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lvl_i == '0) |=> (level_o == '0));

endmodule

// File: rtl/irl_regs.sv
module irl_regs
    import irl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] port_o,
    output logic              shutdown_o
);

    pwr_state_e        state_q;
    pwr_state_e        state_d;
    logic              wr_en;
    logic              rd_en;
    logic              pwr_req;
    logic [DATA_W-1:0] rd_mux;

    assign wr_en   = cs_i & we_i;
    assign rd_en   = cs_i & ~we_i;
    assign pwr_req = wr_en && (addr_i == OFS_PWR) && wdata_i[0];

    // Power-off state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN:   if (pwr_req) state_d = PWR_PULSE;
            PWR_PULSE: state_d = PWR_RUN;
            default:   state_d = PWR_RUN;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        shutdown_o = 1'b0;
        unique case (state_q)
            PWR_RUN:   shutdown_o = 1'b0;
            PWR_PULSE: shutdown_o = 1'b1;
            default:   shutdown_o = 1'b0;
        endcase
    end

    // Writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
            port_o <= '0;
        end else if (wr_en) begin
            if (addr_i == OFS_MASK) mask_o <= wdata_i;
            if (addr_i == OFS_PORT) port_o <= wdata_i;
        end
    end

    always_comb begin
        unique case (addr_i)
            OFS_MASK: rd_mux = mask_o;
            OFS_PORT: rd_mux = port_o;
            OFS_VER:  rd_mux = VERSION_WORD;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_en;
            rdata_o  <= rd_en ? rd_mux : '0;
        end
    end

    // R6: a mask write lands on the next edge
    a_r6_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_i == OFS_MASK) |=> (mask_o == $past(wdata_i)));

    // R8: the pulse lasts one cycle
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |=> !shutdown_o);

    // R8: an accepted request produces the pulse
    a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_req && !shutdown_o) |=> shutdown_o);

    // R9: the version word is constant
    a_r9_version: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr_i == OFS_VER) |=> (rvalid_o && rdata_o == VERSION_WORD));

    // R11: read data is valid exactly one cycle after a read
    a_r11_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid_o);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rvalid_o && rdata_o == '0));

endmodule

// File: rtl/masked_irq_level_enc.sv
module masked_irq_level_enc
    import irl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               cs_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               rvalid_o,
    output logic [LEVEL_W-1:0] level_o,
    output logic [DATA_W-1:0]  port_o,
    output logic               shutdown_o
);

    logic [NUM_SRC-1:0] src_sync;
    logic [DATA_W-1:0]  mask_q;

    irl_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (req_i),
        .sync_o  (src_sync)
    );

    irl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_i       (cs_i),
        .we_i       (we_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o),
        .mask_o     (mask_q),
        .port_o     (port_o),
        .shutdown_o (shutdown_o)
    );

    irl_prio_enc u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lvl_i (src_sync),
        .mask_i    (mask_q),
        .level_o   (level_o)
    );

    // R1: outputs idle in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (level_o == '0 && port_o == '0 && !shutdown_o && !rvalid_o));

endmodule

// File: tb/test_masked_irq_level_enc.sv
module test_masked_irq_level_enc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] req = '0;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;
    logic [3:0]  level;
    logic [15:0] port;
    logic        shutdown;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    masked_irq_level_enc i_masked_irq_level_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .cs_i       (cs),
        .we_i       (we),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .rvalid_o   (rvalid),
        .level_o    (level),
        .port_o     (port),
        .shutdown_o (shutdown)
    );

    // Pending position of the source with priority code k, from R2.
    function automatic int pos_of(input int k);
        int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
        return t[k];
    endfunction

    function automatic logic [3:0] model_level(input logic [12:0] r, input logic [15:0] m);
        for (int k = 0; k < 13; k++) begin
            if (r[k] && m[pos_of(k)]) return 4'(k) ^ 4'hF;
        end
        return 4'h0;
    endfunction

    task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [15:0] d, output logic v);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        cs = 1'b0;
        d = rdata; v = rvalid;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] d;
        logic        v;
        logic [15:0] m;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 level", level, 0);
        check("R1 port", port, 0);
        check("R1 shutdown", shutdown, 0);
        check("R1 rvalid", rvalid, 0);
        bus_read(6'h00, d, v);
        check("R1 mask", d, 0);
        check("R11 rvalid after read", v, 1);

        // R6 mask read/write
        bus_write(6'h00, 16'hFFFF);
        bus_read(6'h00, d, v);
        check("R6 mask readback", d, 16'hFFFF);

        // R5 latency: req change to level on third edge
        @(negedge clk);
        req[0] = 1'b1;
        @(negedge clk); check("R5 edge1", level, 0);
        @(negedge clk); check("R5 edge2", level, 0);
        @(negedge clk); check("R5 edge3 code0 -> 15", level, 15);

        // R3 level-sensitive: dropping clears
        req[0] = 1'b0;
        settle();
        check("R3 drop clears", level, 0);

        // R4 least urgent source alone
        req = 13'h1000;
        settle();
        check("R4 code12", level, 4'd3);

        // R4 lower code wins
        req = 13'h1020;
        settle();
        check("R4 code5 beats code12", level, 4'd10);

        // R6 mask write latency: mask off code5 position (bit 6)
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = 6'h00; wdata = 16'hFFBF;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
        check("R6 level before", level, 4'd10);
        @(negedge clk);
        check("R6 level after", level, 4'd3);

        // R3 mask of everything gives idle
        bus_write(6'h00, 16'h000E);
        req = 13'h1FFF;
        settle();
        check("R3 masked to idle", level, 0);

        // R2 per-source position
        for (int k = 0; k < 13; k++) begin
            bus_write(6'h00, 16'(1) << pos_of(k));
            settle();
            check("R2 position", level, 4'(k) ^ 4'hF);
        end

        // R7 output port
        bus_write(6'h36, 16'hA5C3);
        @(negedge clk);
        check("R7 port pins", port, 16'hA5C3);
        bus_read(6'h36, d, v);
        check("R7 port readback", d, 16'hA5C3);

        // R8 power-off pulse
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = 6'h30; wdata = 16'h0001;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
        check("R8 pulse high", shutdown, 1);
        @(negedge clk);
        check("R8 pulse ends", shutdown, 0);
        bus_write(6'h30, 16'hFFFE);
        check("R8 bit0 clear no pulse", shutdown, 0);
        bus_read(6'h30, d, v);
        check("R8 read zero", d, 0);

        // R9 version
        bus_write(6'h32, 16'h1234);
        bus_read(6'h32, d, v);
        check("R9 version", d, 16'h0010);

        // R10 other offsets
        bus_write(6'h00, 16'h5A5A);
        bus_write(6'h02, 16'hFFFF);
        bus_write(6'h34, 16'h0000);
        bus_write(6'h3E, 16'h1111);
        bus_read(6'h00, d, v);
        check("R10 mask untouched", d, 16'h5A5A);
        bus_read(6'h36, d, v);
        check("R10 port untouched", d, 16'hA5C3);
        bus_read(6'h10, d, v);
        check("R10 other reads zero", d, 0);

        // R11 no valid without read
        @(negedge clk);
        check("R11 idle rvalid", rvalid, 0);
        check("R11 idle rdata", rdata, 0);

        // Random mix for R4
        void'($urandom(32'd2024));
        for (int i = 0; i < 300; i++) begin
            m = 16'($urandom);
            bus_write(6'h00, m);
            req = 13'($urandom);
            if (i % 5 == 0) req = req & 13'($urandom);
            settle();
            check("R4 random", level, model_level(req, m));
        end

        summary();
    end

endmodule